// File: doc/BRIEF.md
# Four-Bit Accumulator Processor

This block is a small single-cycle processor that works on 4-bit data. Every instruction names one operand, and the accumulator is always the other operand. On every clock edge it runs the 8-bit instruction found at the current program address, and then moves to the next address. There are no branches. A program is a straight sequence of up to 32 instructions, and the program repeats after the last address.

The operand is either a 4-bit constant held in the instruction or one of two scratch registers. The 3-bit opcode is also the function code of the arithmetic unit. The accumulator drives the unit's second input and the operand drives the first input. A separate 4-bit register holds the value shown on the LEDs, and it changes only when the program asks for it.

The program store is a 32 x 8 array. It is filled through a write port while the core is held in reset. The accumulator and the program address are also brought out as outputs, so the state of the core can be observed.

Top module: `acc4_core`

## Requirements
- R1: The opcode is in instruction bits 7:5. Bit 4 chooses the operand: 0 selects the constant in bits 3:0, 1 selects a scratch register. When bit 4 is 1, bit 0 picks the register (0 for R0, 1 for R1).
- R2: The arithmetic opcodes update the accumulator, with all results taken modulo 16:
  - 000 adds the operand to the accumulator.
  - 011 subtracts the operand from the accumulator.
  - 100 ANDs the operand with the accumulator.
  - 010 loads the operand into the accumulator.
  - 110 clears the accumulator to 0.
- R3: Opcode 001 copies the accumulator to the LED register. The accumulator does not change.
- R4: Opcode 111 copies the accumulator into R0 or R1, chosen by bit 0. Bit 4 has no effect on this opcode, and the accumulator does not change.
- R5: Opcode 101 changes nothing except the program address.
- R6: The program address goes up by one on every clock edge after reset. After 31 it wraps to 0.
- R7: Reset sets the program address, the accumulator, R0, R1 and the LED register to 0.
- R8: The LED register changes only on opcode 001. R0 and R1 change only on opcode 111.
- R9: Two example programs give known results:
  - 0x47, 0x83, 0xF1, 0x46, 0x85, 0x11, 0x20 shows 7 on the LEDs.
  - 0xC0, 0x07, 0x64, 0x06, 0x83 leaves 1 in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_we | input | 1 | Write strobe for the program store |
| prog_waddr | input | 5 | Program store write address |
| prog_wdata | input | 8 | Instruction byte to write |
| leds | output | 4 | LED register |
| acc_val | output | 4 | Current accumulator value |
| pc_val | output | 5 | Current program address |

## Verification
Properties check on every cycle that the program address steps by one, and that clear gives zero. They also check that output and save leave the accumulator alone, that the no-op leaves the accumulator and LEDs unchanged, that the LEDs hold outside output instructions, and that a save copies the accumulator. Several behaviours can only be shown by the bench's programs running against its reference model:
- the numeric results of the arithmetic opcodes, including modulo-16 wrap;
- the choice between a constant and a register operand;
- the wrap of the program address;
- the reset of scratch registers, which can only be seen through later instructions;
- the two example program results.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  localparam int DW   = 4;
  localparam int IW   = 8;
  localparam int OPW  = 3;
  localparam int NREG = 2;
  localparam int RSW  = $clog2(NREG);

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 3'b000,
    OP_OUT  = 3'b001,
    OP_LOAD = 3'b010,
    OP_SUB  = 3'b011,
    OP_AND  = 3'b100,
    OP_NOP  = 3'b101,
    OP_CLR  = 3'b110,
    OP_SAVE = 3'b111
  } op_e;

  // Arithmetic unit: x is the operand, y is the accumulator.
  function automatic logic [DW-1:0] alu_eval(input logic [OPW-1:0] fn,
                                             input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    case (fn)
      3'b000:  return x + y;
      3'b001:  return x - y;
      3'b010:  return x;
      3'b011:  return y - x;
      3'b100:  return x & y;
      default: return '0;
    endcase
  endfunction

  function automatic logic op_writes_acc(input op_e op);
    return (op == OP_ADD) || (op == OP_LOAD) || (op == OP_SUB) ||
           (op == OP_AND) || (op == OP_CLR);
  endfunction
endpackage

// File: rtl/acc4_progmem.sv
module acc4_progmem
  import acc4_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/acc4_decode.sv
module acc4_decode
  import acc4_pkg::*;
(
  input  logic [IW-1:0]  instr,
  output op_e            op,
  output logic           use_reg,
  output logic [RSW-1:0] reg_idx,
  output logic [DW-1:0]  imm,
  output logic           acc_we,
  output logic           out_we,
  output logic [NREG-1:0] save_we
);
  assign op      = op_e'(instr[IW-1 -: OPW]);
  assign use_reg = instr[DW];
  assign reg_idx = instr[RSW-1:0];
  assign imm     = instr[DW-1:0];
  assign acc_we  = op_writes_acc(op);
  assign out_we  = (op == OP_OUT);

  for (genvar i = 0; i < NREG; i++) begin : g_save
    assign save_we[i] = (op == OP_SAVE) && (reg_idx == RSW'(i));
  end
endmodule

// File: rtl/acc4_datapath.sv
module acc4_datapath
  import acc4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  op_e             op,
  input  logic            use_reg,
  input  logic [RSW-1:0]  reg_idx,
  input  logic [DW-1:0]   imm,
  input  logic            acc_we,
  input  logic            out_we,
  input  logic [NREG-1:0] save_we,
  output logic [DW-1:0]   acc,
  output logic [DW-1:0]   leds
);
  logic [DW-1:0] acc_q, led_q;
  logic [DW-1:0] scr_q [NREG];
  logic [DW-1:0] operand, alu_res;

  assign operand = use_reg ? scr_q[reg_idx] : imm;
  assign alu_res = alu_eval(op, operand, acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_we) acc_q <= alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= '0;
    else if (out_we) led_q <= acc_q;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          scr_q[i] <= '0;
      else if (save_we[i]) scr_q[i] <= acc_q;
    end

    // R4
    save_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_we[i] |=> scr_q[i] == $past(acc_q));

    // R8
    scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_SAVE) |=> $stable(scr_q[i]));
  end

  assign acc  = acc_q;
  assign leds = led_q;

  // R3
  out_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_OUT) |=> $stable(acc_q) && (led_q == $past(acc_q)));

  // R8
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_OUT) |=> $stable(led_q));

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> acc_q == '0);

  // R4
  save_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SAVE) |=> $stable(acc_q));
endmodule

// File: rtl/acc4_core.sv
module acc4_core
  import acc4_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_waddr,
  input  logic [IW-1:0] prog_wdata,
  output logic [DW-1:0] leds,
  output logic [DW-1:0] acc_val,
  output logic [AW-1:0] pc_val
);
  logic [AW-1:0]   pc_q;
  logic            run_q;
  logic [IW-1:0]   instr;
  op_e             op;
  logic            use_reg, acc_we, out_we;
  logic [RSW-1:0]  reg_idx;
  logic [DW-1:0]   imm;
  logic [NREG-1:0] save_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      run_q <= 1'b0;
    end else begin
      pc_q  <= pc_q + 1'b1;
      run_q <= 1'b1;
    end
  end

  acc4_progmem #(.AW(AW)) u_mem (
    .clk(clk), .we(prog_we), .waddr(prog_waddr), .wdata(prog_wdata),
    .raddr(pc_q), .rdata(instr)
  );

  acc4_decode u_dec (
    .instr(instr), .op(op), .use_reg(use_reg), .reg_idx(reg_idx),
    .imm(imm), .acc_we(acc_we), .out_we(out_we), .save_we(save_we)
  );

  acc4_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .op(op), .use_reg(use_reg), .reg_idx(reg_idx),
    .imm(imm), .acc_we(acc_we), .out_we(out_we), .save_we(save_we),
    .acc(acc_val), .leds(leds)
  );

  assign pc_val = pc_q;

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> pc_q == AW'($past(pc_q) + 1'b1));

  // R5
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> $stable(acc_val) && $stable(leds));
endmodule

// File: tb/sim_acc4_core.sv
`timescale 1ns/1ps
module sim_acc4_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_we = 1'b0;
  logic [4:0] prog_waddr = '0;
  logic [7:0] prog_wdata = '0;
  logic [3:0] leds, acc_val;
  logic [4:0] pc_val;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model state
  int m_mem [32];
  int m_pc, m_acc, m_led;
  int m_r [2];
  string last_tag;

  always #2.5 clk = ~clk;

  acc4_core u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_waddr(prog_waddr),
    .prog_wdata(prog_wdata), .leds(leds), .acc_val(acc_val), .pc_val(pc_val)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int ins = m_mem[m_pc];
    int op = (ins >> 5) & 7;
    int x = ((ins >> 4) & 1) ? m_r[ins & 1] : (ins & 15);
    case (op)
      0: begin m_acc = (m_acc + x) % 16;      last_tag = "R2 add"; end
      2: begin m_acc = x;                     last_tag = "R2 load"; end
      3: begin m_acc = (m_acc - x + 16) % 16; last_tag = "R2 sub"; end
      4: begin m_acc = m_acc & x;             last_tag = "R2 and"; end
      6: begin m_acc = 0;                     last_tag = "R2 clr"; end
      1: begin m_led = m_acc;                 last_tag = "R3 out"; end
      7: begin m_r[ins & 1] = m_acc;          last_tag = "R4 save"; end
      default: last_tag = "R5 nop";
    endcase
    m_pc = (m_pc + 1) % 32;
  endtask

  task automatic compare_all();
    check(acc_val == 4'(m_acc), {last_tag, " acc"}, acc_val, m_acc);
    check(leds == 4'(m_led), (last_tag == "R3 out") ? "R3 leds" : "R8 leds", leds, m_led);
    check(pc_val == 5'(m_pc), "R6 pc", pc_val, m_pc);
  endtask

  // Load a program (rest filled with no-op 0xA0) under reset, then release.
  task automatic load_and_reset(input int prog [$]);
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 32; a++) begin
      m_mem[a] = (a < prog.size()) ? prog[a] : 8'hA0;
      prog_we = 1'b1; prog_waddr = 5'(a); prog_wdata = 8'(m_mem[a]);
      @(negedge clk);
    end
    prog_we = 1'b0;
    m_pc = 0; m_acc = 0; m_led = 0; m_r[0] = 0; m_r[1] = 0;
    // R7
    check(pc_val == 0 && acc_val == 0 && leds == 0, "R7 reset state",
          {pc_val, acc_val, leds}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_steps(input int n);
    for (int s = 0; s < n; s++) begin
      @(posedge clk);
      #1;
      model_step();
      compare_all();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: first example program
    load_and_reset('{8'h47, 8'h83, 8'hF1, 8'h46, 8'h85, 8'h11, 8'h20});
    run_steps(7);
    check(leds == 4'd7, "R9 example one leds", leds, 7);

    // R9: second example program
    load_and_reset('{8'hC0, 8'h07, 8'h64, 8'h06, 8'h83});
    run_steps(5);
    check(acc_val == 4'd1, "R9 example two acc", acc_val, 1);

    // Register operands, wraps, no-ops, flag ignored by SAVE
    load_and_reset('{8'h42, 8'h65, 8'hF0, 8'h0F, 8'hF1, 8'hC0, 8'h50, 8'h71,
                     8'h20, 8'hAF, 8'h91, 8'h11, 8'h3F, 8'hEB});
    run_steps(2);
    check(acc_val == 4'd13, "R2 sub wraps modulo 16", acc_val, 13);
    run_steps(5);
    check(acc_val == 4'd13, "R4 save then load R0", acc_val, 13);
    run_steps(1);
    check(acc_val == 4'd1, "R1 register operand bit0 selects R1", acc_val, 1);
    run_steps(2);
    check(leds == 4'd1 && acc_val == 4'd1, "R5 no-op keeps state", {leds, acc_val}, 8'h11);
    run_steps(3);
    check(leds == 4'd12, "R3 out with junk low bits", leds, 12);
    run_steps(19);
    check(pc_val == 5'd0, "R6 pc wraps after 31", pc_val, 0);
    run_steps(8);

    // R7: mid-run reset clears R1 (observed through ADD R1 and OUT)
    load_and_reset('{8'h45, 8'h11, 8'h20});
    run_steps(3);
    check(leds == 4'd5, "R7 scratch cleared by reset", leds, 5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule